// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write an external 8K x 8 asynchronous static RAM. The RAM has one active-low enable and one active-high enable, a write strobe and an output enable. The host hands over one access at a time through a valid/ready handshake that carries a direction flag, an address and write data. Each read returns its byte together with a one-cycle response pulse.

The clock period is a parameter, `CLK_NS`. Every analog minimum of the memory becomes a cycle count, computed at elaboration time as the ceiling of the time divided by `CLK_NS`, and never less than one cycle. A read selects the chip and presents the address. It then lowers the output enable and waits out both the address access time and the output-enable access time before it captures the bus. A write first lets any previous read data leave the bus. It then lowers the write strobe for a window long enough to meet the pulse width, the data setup time and the address-valid time. It holds the data for one more cycle after the strobe returns high.

The pad tri-state buffer stays outside the block. The block drives a data-out vector and a separate drive-enable, and it takes the pad's input value back on a data-in vector.

Top module: `sram_seq_ctrl`

## Requirements
- R1: In reset and whenever idle, the block deselects the memory (low-active enable high, high-active enable low), keeps the write strobe and output enable high, and releases the data bus (drive-enable low).
- R2: `req_ready` is high only while idle. A request is taken only on a cycle where `req_valid` and `req_ready` are both high; a `req_valid` pulse while busy has no effect on memory contents.
- R3: On a read, the address and both enables stay asserted for at least ceil(200/CLK_NS) cycles, and the output enable stays low for at least ceil(150/CLK_NS) cycles, before the clock edge that captures the data bus.
- R4: After each read, `rsp_valid` is high for exactly one cycle and carries the captured byte on `rsp_rdata`. A write raises no response pulse.
- R5: The write strobe is low only while both enables are asserted, and each low pulse lasts at least ceil(150/CLK_NS) cycles.
- R6: Write data is driven and stable for at least ceil(100/CLK_NS) cycles before the write strobe rises. It is still driven, unchanged, in the cycle in which the strobe is high again.
- R7: The address and both enables are valid for at least ceil(180/CLK_NS) cycles before the write strobe rises.
- R8: The data bus is driven only while the output enable is high, and only once at least ceil(40/CLK_NS) cycles have passed since it last rose.
- R9: The address does not change while the memory is selected. Every access keeps the memory selected at one address for at least ceil(200/CLK_NS) cycles.
- R10: The output enable stays high for the whole of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS ns |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data is valid |
| rsp_rdata | output | DATA_W | Captured read byte |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_en_lo_n | output | 1 | Memory enable, active low |
| sram_en_hi | output | 1 | Memory enable, active high |
| sram_wr_n | output | 1 | Write strobe, active low |
| sram_out_en_n | output | 1 | Memory output enable, active low |
| sram_dq_out | output | DATA_W | Data toward the pad buffer |
| sram_dq_drive | output | 1 | Pad buffer drive enable |
| sram_dq_in | input | DATA_W | Data from the pad buffer |

## Verification
The bench puts a cycle-level model of the memory on the pins. The model returns a poison byte until both read windows have elapsed, so a read sequencer that is one cycle short brings back 0xEE instead of the stored byte. The model commits a write only when the strobe width, the data setup, the address-valid time and the data hold are all met. A write that breaks any of them is lost, and the next read-back shows it. A monitor watches the data bus. It flags any drive that begins before the output-disable time has passed, and any deselect that comes too early. Directed cases cover the address extremes, an overwrite, and a request pulsed in the middle of a busy read that must not land in memory.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_SETUP,
      S_RD_WAIT,
      S_RD_DONE,
      S_WR_TURN,
      S_WR_PULSE,
      S_WR_END
   } seq_state_e;

   typedef struct packed {
      logic en_lo_n;
      logic en_hi;
      logic wr_n;
      logic oe_n;
      logic drive;
      logic resp;
   } strobe_t;

   // ceiling of t_ns / clk_ns, never below one cycle
   function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
      int c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // pin levels for every sequencer state
   function automatic strobe_t strobe_of(input seq_state_e s);
      strobe_t o;
      o.en_lo_n = 1'b1;
      o.en_hi   = 1'b0;
      o.wr_n    = 1'b1;
      o.oe_n    = 1'b1;
      o.drive   = 1'b0;
      o.resp    = 1'b0;
      case (s)
         S_RD_SETUP: begin
            o.en_lo_n = 1'b0;
            o.en_hi   = 1'b1;
         end
         S_RD_WAIT: begin
            o.en_lo_n = 1'b0;
            o.en_hi   = 1'b1;
            o.oe_n    = 1'b0;
         end
         S_RD_DONE: begin
            o.resp    = 1'b1;
         end
         S_WR_TURN: begin
            o.en_lo_n = 1'b0;
            o.en_hi   = 1'b1;
         end
         S_WR_PULSE: begin
            o.en_lo_n = 1'b0;
            o.en_hi   = 1'b1;
            o.wr_n    = 1'b0;
            o.drive   = 1'b1;
         end
         S_WR_END: begin
            o.en_lo_n = 1'b0;
            o.en_hi   = 1'b1;
            o.drive   = 1'b1;
         end
         default: ;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // a new window may only start once the running one is used up
   AST_LOAD_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (rst)
      load |-> expired);   // R9

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int CNT_W  = 5,
   parameter int D_RDW  = 24,
   parameter int D_TURN = 5,
   parameter int D_WPL  = 19,
   parameter int D_END  = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_fire,
   input  logic             req_write,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output seq_state_e       state_q,
   output seq_state_e       state_d
);

   localparam logic [CNT_W-1:0] L_RDW  = CNT_W'(D_RDW - 1);
   localparam logic [CNT_W-1:0] L_TURN = CNT_W'(D_TURN - 1);
   localparam logic [CNT_W-1:0] L_WPL  = CNT_W'(D_WPL - 1);
   localparam logic [CNT_W-1:0] L_END  = CNT_W'(D_END - 1);

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         S_IDLE: begin
            if (req_fire) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  state_d = S_WR_TURN;
                  tmr_val = L_TURN;
               end else begin
                  state_d = S_RD_SETUP;
                  tmr_val = '0;
               end
            end
         end
         S_RD_SETUP: if (tmr_expired) begin
            state_d  = S_RD_WAIT;
            tmr_load = 1'b1;
            tmr_val  = L_RDW;
         end
         S_RD_WAIT: if (tmr_expired) begin
            state_d  = S_RD_DONE;
            tmr_load = 1'b1;
            tmr_val  = '0;
         end
         S_RD_DONE: if (tmr_expired) state_d = S_IDLE;
         S_WR_TURN: if (tmr_expired) begin
            state_d  = S_WR_PULSE;
            tmr_load = 1'b1;
            tmr_val  = L_WPL;
         end
         S_WR_PULSE: if (tmr_expired) begin
            state_d  = S_WR_END;
            tmr_load = 1'b1;
            tmr_val  = L_END;
         end
         S_WR_END: if (tmr_expired) state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= S_IDLE;
      else     state_q <= state_d;
   end

   AST_FIRE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
      (state_q != S_IDLE) |=> (state_q != S_RD_SETUP || $past(state_q) == S_IDLE || $past(state_q) == S_RD_SETUP)); // R2

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_fire,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  seq_state_e        state_q,
   input  seq_state_e        state_d,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] rd_data,
   output strobe_t           pins
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              capture;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (req_fire) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   // bus is sampled on the edge that closes the read window
   assign capture = (state_q == S_RD_WAIT) && (state_d == S_RD_DONE);

   always_ff @(posedge clk) begin
      if (rst)          rdata_q <= '0;
      else if (capture) rdata_q <= dq_in;
   end

   generate
      if (OUT_REG) begin : g_reg_pins
         strobe_t pins_q;
         always_ff @(posedge clk) begin
            if (rst) pins_q <= strobe_of(S_IDLE);
            else     pins_q <= strobe_of(state_d);
         end
         assign pins = pins_q;
      end else begin : g_comb_pins
         assign pins = strobe_of(state_q);
      end
   endgenerate

   assign mem_addr = addr_q;
   assign dq_out   = wdata_q;
   assign rd_data  = rdata_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 8,
   parameter int CLK_NS   = 8,
   parameter int T_RC_NS  = 200,
   parameter int T_WC_NS  = 200,
   parameter int T_AA_NS  = 200,
   parameter int T_OE_NS  = 150,
   parameter int T_WP_NS  = 150,
   parameter int T_DW_NS  = 100,
   parameter int T_AW_NS  = 180,
   parameter int T_OHZ_NS = 40,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_en_lo_n,
   output logic              sram_en_hi,
   output logic              sram_wr_n,
   output logic              sram_out_en_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_drive,
   input  logic [DATA_W-1:0] sram_dq_in
);

   // analog minima as cycle counts
   localparam int N_RC  = ns_to_cyc(T_RC_NS,  CLK_NS);
   localparam int N_WC  = ns_to_cyc(T_WC_NS,  CLK_NS);
   localparam int N_AA  = ns_to_cyc(T_AA_NS,  CLK_NS);
   localparam int N_OE  = ns_to_cyc(T_OE_NS,  CLK_NS);
   localparam int N_WP  = ns_to_cyc(T_WP_NS,  CLK_NS);
   localparam int N_DW  = ns_to_cyc(T_DW_NS,  CLK_NS);
   localparam int N_AW  = ns_to_cyc(T_AW_NS,  CLK_NS);
   localparam int N_OHZ = ns_to_cyc(T_OHZ_NS, CLK_NS);

   // state durations in cycles
   localparam int D_TURN = N_OHZ;
   localparam int D_RDW  = imax(imax(N_AA - 1, N_OE), imax(N_RC - 1, 1));
   localparam int D_WPL  = imax(imax(N_WP, N_DW), N_AW - D_TURN);
   localparam int D_END  = imax(1, N_WC - D_TURN - D_WPL);
   localparam int D_MAX  = imax(imax(D_RDW, D_TURN), imax(D_WPL, D_END));
   localparam int CNT_W  = $clog2(D_MAX + 1);

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         initial $fatal(1, "CLK_NS must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         initial $fatal(1, "ADDR_W and DATA_W must be at least 1");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic             tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val;
   logic             req_fire;
   strobe_t          pins;

   assign req_ready = (state_q == S_IDLE);
   assign req_fire  = req_valid && req_ready;

   sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sram_seq_fsm #(
      .CNT_W  (CNT_W),
      .D_RDW  (D_RDW),
      .D_TURN (D_TURN),
      .D_WPL  (D_WPL),
      .D_END  (D_END)
   ) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .req_fire    (req_fire),
      .req_write   (req_write),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .state_q     (state_q),
      .state_d     (state_d)
   );

   sram_seq_datapath #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .OUT_REG (OUT_REG)
   ) u_dp (
      .clk       (clk),
      .rst       (rst),
      .req_fire  (req_fire),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .state_q   (state_q),
      .state_d   (state_d),
      .dq_in     (sram_dq_in),
      .mem_addr  (sram_addr),
      .dq_out    (sram_dq_out),
      .rd_data   (rsp_rdata),
      .pins      (pins)
   );

   assign sram_en_lo_n  = pins.en_lo_n;
   assign sram_en_hi    = pins.en_hi;
   assign sram_wr_n     = pins.wr_n;
   assign sram_out_en_n = pins.oe_n;
   assign sram_dq_drive = pins.drive;
   assign rsp_valid     = pins.resp;

   // ---------------- window counters for the checks below ----------------
   localparam int OHZ_W = $clog2(N_OHZ + 1);
   localparam int WL_W  = $clog2(N_WP + 1);
   localparam int AW_W  = $clog2(N_AW + 1);

   logic [OHZ_W-1:0] oe_hi_cnt;
   logic [WL_W-1:0]  wr_lo_cnt;
   logic [AW_W-1:0]  sel_cnt;

   always_ff @(posedge clk) begin
      if (rst)                                 oe_hi_cnt <= OHZ_W'(N_OHZ);
      else if (!sram_out_en_n)                 oe_hi_cnt <= '0;
      else if (oe_hi_cnt < OHZ_W'(N_OHZ))      oe_hi_cnt <= oe_hi_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)                                 wr_lo_cnt <= '0;
      else if (sram_wr_n)                      wr_lo_cnt <= '0;
      else if (wr_lo_cnt < WL_W'(N_WP))        wr_lo_cnt <= wr_lo_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)                                 sel_cnt <= '0;
      else if (sram_en_lo_n || !sram_en_hi)    sel_cnt <= '0;
      else if (sel_cnt < AW_W'(N_AW))          sel_cnt <= sel_cnt + 1'b1;
   end

   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (sram_en_lo_n && !sram_en_hi && sram_wr_n && sram_out_en_n && !sram_dq_drive)); // R1
   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid); // R4
   AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
      !sram_wr_n |-> (!sram_en_lo_n && sram_en_hi)); // R5
   AST_WR_WIDTH: assert property (@(posedge clk) disable iff (rst)
      $rose(sram_wr_n) |-> (wr_lo_cnt >= WL_W'(N_WP))); // R5
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
      $rose(sram_wr_n) |-> (sram_dq_drive && $stable(sram_dq_out))); // R6
   AST_AW_WINDOW: assert property (@(posedge clk) disable iff (rst)
      $rose(sram_wr_n) |-> (sel_cnt >= AW_W'(N_AW))); // R7
   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
      sram_dq_drive |-> (sram_out_en_n && oe_hi_cnt >= OHZ_W'(N_OHZ))); // R8
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
      (!sram_en_lo_n && $past(!sram_en_lo_n)) |-> $stable(sram_addr)); // R9
   AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
      !sram_wr_n |-> sram_out_en_n); // R10

endmodule

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;

   localparam int CLK_NS = 8;
   localparam int AW = 13;
   localparam int DW = 8;
   localparam int NB_RC  = (200 + CLK_NS - 1) / CLK_NS;
   localparam int NB_AA  = (200 + CLK_NS - 1) / CLK_NS;
   localparam int NB_OE  = (150 + CLK_NS - 1) / CLK_NS;
   localparam int NB_WP  = (150 + CLK_NS - 1) / CLK_NS;
   localparam int NB_DW  = (100 + CLK_NS - 1) / CLK_NS;
   localparam int NB_AW  = (180 + CLK_NS - 1) / CLK_NS;
   localparam int NB_OHZ = (40  + CLK_NS - 1) / CLK_NS;
   localparam logic [DW-1:0] POISON = 8'hEE;

   // {write, addr[12:0], data[7:0]}; for reads data is the expected byte
   localparam int NV = 10;
   localparam logic [21:0] VEC [NV] = '{
      {1'b1, 13'h0000, 8'h5A},
      {1'b1, 13'h1FFF, 8'hA5},
      {1'b0, 13'h0000, 8'h5A},
      {1'b0, 13'h1FFF, 8'hA5},
      {1'b1, 13'h0123, 8'h3C},
      {1'b1, 13'h0123, 8'hC3},
      {1'b0, 13'h0123, 8'hC3},
      {1'b1, 13'h1000, 8'h00},
      {1'b0, 13'h1000, 8'h00},
      {1'b0, 13'h1FFF, 8'hA5}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] sram_addr;
   logic sram_en_lo_n, sram_en_hi, sram_wr_n, sram_out_en_n, sram_dq_drive;
   logic [DW-1:0] sram_dq_out;
   logic [DW-1:0] sram_dq_in = POISON;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_NS / 2) clk = ~clk;

   sram_seq_ctrl #(.CLK_NS(CLK_NS)) uut (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_en_lo_n(sram_en_lo_n), .sram_en_hi(sram_en_hi),
      .sram_wr_n(sram_wr_n), .sram_out_en_n(sram_out_en_n),
      .sram_dq_out(sram_dq_out), .sram_dq_drive(sram_dq_drive), .sram_dq_in(sram_dq_in)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
      return a[7:0] ^ 8'h69;
   endfunction

   // ---------------- cycle-level memory model ----------------
   logic [DW-1:0] mem [1 << AW];
   int sel_cnt = 0, wl_cnt = 0, dat_cnt = 0, oel_cnt = 0, ohz_cnt = 1000;
   bit prev_sel = 0, prev_wr_n = 1, prev_drive = 0, oe_low_in_wr = 0;
   logic [AW-1:0] prev_addr = '0;
   logic [DW-1:0] prev_dq = '0;

   initial for (int i = 0; i < (1 << AW); i++) mem[i] = init_val(AW'(i));

   always @(negedge clk) begin
      bit sel;
      sel = !sram_en_lo_n && sram_en_hi;
      if (!rst) begin
         if (!sram_wr_n && !sram_out_en_n) oe_low_in_wr = 1;
         // write strobe rising: all windows judged on the cycles before
         if (!prev_wr_n && sram_wr_n) begin
            check(wl_cnt >= NB_WP, "R5 strobe width", wl_cnt, NB_WP);
            check(dat_cnt >= NB_DW, "R6 data setup", dat_cnt, NB_DW);
            check(sram_dq_drive && sram_dq_out == prev_dq, "R6 data hold",
                  {sram_dq_drive, sram_dq_out}, {1'b1, prev_dq});
            check(sel_cnt >= NB_AW, "R7 address valid", sel_cnt, NB_AW);
            check(!oe_low_in_wr, "R10 output enable during write", oe_low_in_wr, 0);
            oe_low_in_wr = 0;
            if (wl_cnt >= NB_WP && dat_cnt >= NB_DW && sel_cnt >= NB_AW && sram_dq_drive)
               mem[prev_addr] = prev_dq;
         end
         if (sram_dq_drive && !prev_drive)
            check(sram_out_en_n && ohz_cnt >= NB_OHZ, "R8 bus turnaround", ohz_cnt, NB_OHZ);
         if (prev_sel && !sel)
            check(sel_cnt >= NB_RC, "R9 access length", sel_cnt, NB_RC);
      end
      if (sel && prev_sel && sram_addr == prev_addr) sel_cnt++;
      else if (sel) sel_cnt = 1;
      else sel_cnt = 0;
      wl_cnt  = sram_wr_n ? 0 : wl_cnt + 1;
      oel_cnt = sram_out_en_n ? 0 : oel_cnt + 1;
      if (sram_out_en_n) begin if (ohz_cnt < 1000) ohz_cnt++; end
      else ohz_cnt = 0;
      if (sram_dq_drive && prev_drive && sram_dq_out == prev_dq) dat_cnt++;
      else if (sram_dq_drive) dat_cnt = 1;
      else dat_cnt = 0;
      if (sel && !sram_out_en_n && sel_cnt >= NB_AA && oel_cnt >= NB_OE)
         sram_dq_in = mem[sram_addr];
      else
         sram_dq_in = POISON;
      prev_sel = sel; prev_wr_n = sram_wr_n; prev_drive = sram_dq_drive;
      prev_addr = sram_addr; prev_dq = sram_dq_out;
   end

   // ---------------- host tasks ----------------
   task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd);
      int n;
      bit pulsed;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0;
      check(!req_ready, "R2 ready drops when busy", req_ready, 0);
      rd = '0;
      pulsed = 0;
      n = 0;
      if (!w) begin
         while (!rsp_valid && n < 1000) begin @(negedge clk); n++; end
         rd = rsp_rdata;
         @(negedge clk);
         check(!rsp_valid, "R4 response is one cycle", rsp_valid, 0);
      end else begin
         while (!req_ready && n < 1000) begin
            if (rsp_valid) pulsed = 1;
            @(negedge clk); n++;
         end
         check(!pulsed, "R4 no response on write", pulsed, 0);
      end
   endtask

   initial begin : watchdog
      #(CLK_NS * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R2 watchdog: still busy, expected completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] rd;
      repeat (4) @(negedge clk);
      check(sram_en_lo_n && !sram_en_hi && sram_wr_n && sram_out_en_n && !sram_dq_drive,
            "R1 pins in reset", {sram_en_lo_n, sram_en_hi, sram_wr_n, sram_out_en_n, sram_dq_drive},
            5'b10110);
      check(!rsp_valid, "R4 no response in reset", rsp_valid, 0);
      rst = 0;
      @(negedge clk);
      check(req_ready, "R1 ready after reset", req_ready, 1);

      // table walk
      for (int i = 0; i < NV; i++) begin
         access(VEC[i][21], VEC[i][20:8], VEC[i][7:0], rd);
         if (!VEC[i][21])
            check(rd == VEC[i][7:0], "R3 read data", rd, VEC[i][7:0]);
      end

      // idle state between accesses
      @(negedge clk);
      check(req_ready && sram_en_lo_n && !sram_en_hi && !sram_dq_drive,
            "R1 idle pins", {req_ready, sram_en_lo_n, sram_en_hi, sram_dq_drive}, 4'b1100);

      // untouched location returns its initial pattern
      access(0, 13'h0ABC, 8'h00, rd);
      check(rd == init_val(13'h0ABC), "R3 untouched read", rd, init_val(13'h0ABC));

      // request pulsed while busy must be ignored
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 13'h0000;
      @(negedge clk);
      req_valid = 0;
      repeat (5) @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 13'h0777; req_wdata = 8'h11;
      @(negedge clk);
      req_valid = 0;
      while (!req_ready) @(negedge clk);
      access(0, 13'h0777, 8'h00, rd);
      check(rd == init_val(13'h0777), "R2 busy request ignored", rd, init_val(13'h0777));

      // write immediately after read exercises the bus turnaround
      access(0, 13'h1FFF, 8'h00, rd);
      access(1, 13'h0042, 8'hE1, rd);
      access(0, 13'h0042, 8'h00, rd);
      check(rd == 8'hE1, "R8 write after read lands", rd, 8'hE1);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule